// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Summary

A register-mapped bank of general-purpose pins. Every pin owns one 32-bit word that holds its output value and output driver enable, reports its synchronized input level, and sets up interrupt detection. Detection can be edge or level triggered, active high or active low, or, for edges, on both transitions. A detection enable and a separate delivery mask control each pin. Pending events are combined into a summary vector with one bit per group of four pins. One registered interrupt line goes to the host.

The host services an interrupt in four steps. It reads the summary words to find the active groups. It reads the words of the pins in those groups and writes back each word with the status bit set, which clears that pin's status. It then writes the end-of-interrupt bit of the master register. That write forces the line low for one cycle, so an interrupt controller that triggers on edges sees a new edge if any status is still pending. Register reads return data one cycle after the read strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq` is 0, `pin_out` and `pin_oe` are all 0, and every pin word reads 0 apart from its input level bit.
- R2: Pin n's word sits at byte address 4n. Only bits 8, 9, 10, 11, 12, 22 and 23 are writable, and the other bits read back as 0 except the status bit 28 and the input level bit 16. A slot with no pin reads 0 and ignores writes. Accesses whose address bits 1:0 are not zero are ignored.
- R3: `pin_out[n]` equals bit 22 and `pin_oe[n]` equals bit 23 of pin n's word, both valid in the cycle after the write.
- R4: Bit 16 reports the pin input after a two-flop synchronizer. A change applied before rising edge k is first returned by a read sampled at edge k+2.
- R5: With bit 8 clear (edge mode), status bit 28 is set on a rising edge when bits 10:9 are 00, on a falling edge when bit 9 alone is set, and on either edge when bit 10 is set. The status stays set until the word is written with bit 28 = 1.
- R6: With bit 8 set (level mode), status is set on every cycle in which the level is active. The level is low when bit 9 is set without bit 10, and high otherwise. A clear write has no effect while the level is still active.
- R7: With bit 11 clear, no new status is set on any input activity.
- R8: Summary bit i is set when any pin from 4i to 4i+3 has status set and bit 12 set. The low 32 summary bits read at 0x2F8 and the high bits at 0x2FC. Bits for groups that have no pins read 0.
- R9: `irq` is a register that is 1 in the cycle after any summary bit is set, unless an end-of-interrupt write occurred in that cycle.
- R10: Writing bit 29 = 1 to address 0xFC forces `irq` to 0 for the next cycle, after which the line follows R9 again. The master register, including bit 29, always reads 0. With more than 63 pins, pin slot 63 is taken by this register and holds no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output driver enables |
| irq | output | 1 | Interrupt line to the host |

## Verification
The hardest situations to reach are those where a write and a detection land on the same clock edge. Examples are a clear written while a level is still active, and an end-of-interrupt written while status stays pending, so the line must drop for exactly one cycle and then return. Directed sequences hold the input at its active level across the clear write. They issue the end-of-interrupt while a latched edge status is still uncleared and sample `irq` in each of the following two cycles. A random phase then mixes input toggles, arbitrary configuration writes, reads and end-of-interrupt writes, so these collisions also occur at unplanned phases. A behavioural model checks every cycle of that phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Field positions inside a pin word (host software decodes these)
  localparam int B_LEVEL   = 8;
  localparam int B_ACT_LO  = 9;
  localparam int B_BOTH    = 10;
  localparam int B_DET_EN  = 11;
  localparam int B_DLV_EN  = 12;
  localparam int B_IN_LVL  = 16;
  localparam int B_OUT_VAL = 22;
  localparam int B_OUT_EN  = 23;
  localparam int B_PEND    = 28;
  localparam int B_EOI     = 29;

  typedef struct packed {
    logic out_en;
    logic out_val;
    logic dlv_en;
    logic det_en;
    logic both;
    logic act_lo;
    logic level;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      lvl  <= '0;
      prev <= '0;
    end else begin
      meta <= din;
      lvl  <= meta;
      prev <= lvl;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_sel,
  input  logic [31:0] wdata,
  input  logic        lvl,
  input  logic        prev,
  output pin_cfg_t    cfg,
  output logic        pend
);
  logic rise, fall, edge_hit, lvl_hit, hit, clr;

  always_comb begin
    rise     = lvl & ~prev;
    fall     = ~lvl & prev;
    edge_hit = cfg.both ? (rise | fall) : (cfg.act_lo ? fall : rise);
    lvl_hit  = (cfg.act_lo & ~cfg.both) ? ~lvl : lvl;
    hit      = cfg.det_en & (cfg.level ? lvl_hit : edge_hit);
    clr      = wr_sel & wdata[B_PEND];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      pend <= 1'b0;
    end else begin
      if (wr_sel) begin
        cfg.out_en  <= wdata[B_OUT_EN];
        cfg.out_val <= wdata[B_OUT_VAL];
        cfg.dlv_en  <= wdata[B_DLV_EN];
        cfg.det_en  <= wdata[B_DET_EN];
        cfg.both    <= wdata[B_BOTH];
        cfg.act_lo  <= wdata[B_ACT_LO];
        cfg.level   <= wdata[B_LEVEL];
      end
      pend <= hit | (pend & ~clr);
    end
  end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS = 32,
  parameter int GROUP    = 4,
  parameter int SUM_W    = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pend_vec,
  input  logic [NUM_PINS-1:0] dlv_vec,
  input  logic                eoi,
  output logic [SUM_W-1:0]    sum_vec,
  output logic                irq
);
  localparam int NUM_GROUPS = (NUM_PINS + GROUP - 1) / GROUP;
  localparam int PAD_W      = NUM_GROUPS * GROUP;

  logic [PAD_W-1:0] live;
  assign live = PAD_W'(pend_vec & dlv_vec);

  for (genvar g = 0; g < SUM_W; g++) begin : g_sum
    if (g < NUM_GROUPS) begin : g_used
      assign sum_vec[g] = |live[g*GROUP +: GROUP];
    end else begin : g_empty
      assign sum_vec[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ~eoi & (|sum_vec);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 10,
  parameter int GROUP       = 4,
  parameter int MASTER_ADDR = 'h0FC,
  parameter int SUM_LO_ADDR = 'h2F8,
  parameter int SUM_HI_ADDR = 'h2FC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SUM_W = 64;
  localparam int HOLE  = MASTER_ADDR / 4;

  logic [NUM_PINS-1:0] lvl_vec, prev_vec, pend_vec, dlv_vec, det_vec;
  logic [SUM_W-1:0]    sum_vec;
  logic [31:0]         pin_word [NUM_PINS];
  logic [IDX_W-1:0]    idx;
  logic                aligned, eoi;
  logic [31:0]         rd_mux;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign eoi     = reg_wr && (reg_addr == ADDR_W'(MASTER_ADDR)) && reg_wdata[B_EOI];

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .lvl(lvl_vec), .prev(prev_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == HOLE) begin : g_hole
      assign pend_vec[p] = 1'b0;
      assign dlv_vec[p]  = 1'b0;
      assign det_vec[p]  = 1'b0;
      assign pin_out[p]  = 1'b0;
      assign pin_oe[p]   = 1'b0;
      assign pin_word[p] = '0;
    end else begin : g_cell
      pin_cfg_t cfg;
      logic     sel;
      assign sel = reg_wr && aligned && (idx == IDX_W'(p));

      gpio_pin_cell u_cell (
        .clk(clk), .rst(rst), .wr_sel(sel), .wdata(reg_wdata),
        .lvl(lvl_vec[p]), .prev(prev_vec[p]), .cfg(cfg), .pend(pend_vec[p])
      );

      assign dlv_vec[p] = cfg.dlv_en;
      assign det_vec[p] = cfg.det_en;
      assign pin_out[p] = cfg.out_val;
      assign pin_oe[p]  = cfg.out_en;

      always_comb begin
        pin_word[p]            = '0;
        pin_word[p][B_LEVEL]   = cfg.level;
        pin_word[p][B_ACT_LO]  = cfg.act_lo;
        pin_word[p][B_BOTH]    = cfg.both;
        pin_word[p][B_DET_EN]  = cfg.det_en;
        pin_word[p][B_DLV_EN]  = cfg.dlv_en;
        pin_word[p][B_IN_LVL]  = lvl_vec[p];
        pin_word[p][B_OUT_VAL] = cfg.out_val;
        pin_word[p][B_OUT_EN]  = cfg.out_en;
        pin_word[p][B_PEND]    = pend_vec[p];
      end
    end
  end

  gpio_irq_summary #(.NUM_PINS(NUM_PINS), .GROUP(GROUP), .SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst(rst), .pend_vec(pend_vec), .dlv_vec(dlv_vec),
    .eoi(eoi), .sum_vec(sum_vec), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(SUM_LO_ADDR)) begin
      rd_mux = sum_vec[31:0];
    end else if (reg_addr == ADDR_W'(SUM_HI_ADDR)) begin
      rd_mux = sum_vec[63:32];
    end else if (aligned) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (idx == IDX_W'(p)) rd_mux = pin_word[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 10,
  parameter int MASTER_ADDR = 'h0FC
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [63:0]         sum_vec,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] det_vec
);
  logic eoi_wr;
  assign eoi_wr = reg_wr && (reg_addr == ADDR_W'(MASTER_ADDR)) && reg_wdata[29];

  // R3: pin 0 output and enable follow the written bits
  a_r3_out_follows_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(0)) |=>
      (pin_out[0] == $past(reg_wdata[22]) && pin_oe[0] == $past(reg_wdata[23])));

  // R7: no status appears on a pin whose detection was off
  a_r7_no_detect_no_status: assert property (@(posedge clk) disable iff (rst)
    ((pend_vec & ~$past(pend_vec) & ~$past(det_vec)) == '0));

  // R9: the line only rises from a pending summary
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|sum_vec));

  // R9: a pending summary without end-of-interrupt raises the line
  a_r9_irq_follows_sum: assert property (@(posedge clk) disable iff (rst)
    ((|sum_vec) && !eoi_wr) |=> irq);

  // R10: end-of-interrupt forces a low cycle
  a_r10_eoi_gap: assert property (@(posedge clk) disable iff (rst)
    eoi_wr |=> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .MASTER_ADDR(MASTER_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .sum_vec(sum_vec), .pend_vec(pend_vec), .det_vec(det_vec)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam logic [31:0] WMASK = 32'h00C0_1F00;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_cfg [NP];
  bit [NP-1:0] m_s1, m_s2, m_prev, m_pend, ev;
  bit m_irq;
  bit [31:0] m_rdata;
  bit [63:0] sm;
  bit eoi_now;
  int widx;

  function automatic bit fire(int p);
    if (!m_cfg[p][11]) return 0;
    if (m_cfg[p][8]) return (m_cfg[p][9] && !m_cfg[p][10]) ? !m_s2[p] : m_s2[p];
    if (m_cfg[p][10]) return m_s2[p] != m_prev[p];
    if (m_cfg[p][9]) return m_prev[p] && !m_s2[p];
    return m_s2[p] && !m_prev[p];
  endfunction

  function automatic bit [63:0] summ();
    bit [63:0] s = '0;
    for (int p = 0; p < NP; p++)
      if (m_pend[p] && m_cfg[p][12]) s[p/4] = 1'b1;
    return s;
  endfunction

  function automatic bit [31:0] peek(bit [9:0] a);
    bit [63:0] s = summ();
    int i = int'(a) / 4;
    if (a == 10'h2F8) return s[31:0];
    if (a == 10'h2FC) return s[63:32];
    if (a[1:0] != 2'b00 || i >= NP || i == 63) return '0;
    return m_cfg[i] | (32'(m_s2[i]) << 16) | (32'(m_pend[i]) << 28);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) m_cfg[p] = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_irq = 0; m_rdata = '0;
    end else begin
      for (int p = 0; p < NP; p++) ev[p] = fire(p);
      sm = summ();
      if (reg_rd) m_rdata = peek(reg_addr);
      eoi_now = reg_wr && reg_addr == 10'h0FC && reg_wdata[29];
      m_irq = !eoi_now && (sm != 0);
      widx = (reg_addr[1:0] == 2'b00) ? int'(reg_addr) / 4 : -1;
      for (int p = 0; p < NP; p++) begin
        m_pend[p] = ev[p] || (m_pend[p] && !(reg_wr && widx == p && reg_wdata[28]));
        if (reg_wr && widx == p) m_cfg[p] = reg_wdata & WMASK;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic bit [NP-1:0] m_bit(int b);
    bit [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = m_cfg[p][b];
    return v;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R9 irq vs model", 32'(irq), 32'(m_irq));
      chk("R3 pin_out vs model", pin_out, m_bit(22));
      chk("R3 pin_oe vs model", pin_oe, m_bit(23));
      chk("R2 rdata vs model", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(bit [9:0] a, bit [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(bit [9:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d, d1, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    // R1: reset state
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 pin_oe after reset", pin_oe, 0);
    rd(10'h000, d); chk("R1 pin0 word", d, 0);

    // R3: outputs
    wr(10'h014, 32'h00C0_0000);
    chk("R3 out5 high", 32'(pin_out[5]), 1);
    chk("R3 oe5 high", 32'(pin_oe[5]), 1);
    wr(10'h014, 32'h0080_0000);
    chk("R3 out5 low", 32'(pin_out[5]), 0);

    // R2: writable mask, unmapped slot, misaligned write
    wr(10'h008, 32'hFFFF_FFFF);
    rd(10'h008, d); chk("R2 reserved bits", d, 32'h00C0_1F00);
    wr(10'h008, 32'h0);
    wr(10'h0A0, 32'hFFFF_FFFF);
    rd(10'h0A0, d); chk("R2 empty slot", d, 0);
    wr(10'h00D, 32'h00C0_0000);
    chk("R2 misaligned ignored", 32'(pin_oe[3]), 0);
    rd(10'h0FC, d); chk("R10 master reads 0", d, 0);

    // R4: two-flop synchronizer latency
    pin_in[7] = 1'b1;
    rd(10'h01C, d); rd(10'h01C, d1); rd(10'h01C, d2);
    chk("R4 edge k", d, 0);
    chk("R4 edge k+1", d1, 0);
    chk("R4 edge k+2", d2, 32'h0001_0000);

    // R5: rising on pin 0
    wr(10'h000, 32'h0000_1800);
    pin_in[0] = 1'b1; idle(6);
    chk("R9 irq from pin0", 32'(irq), 1);
    rd(10'h2F8, d); chk("R8 summary group0", d, 1);
    rd(10'h000, d); chk("R5 rise status", d, 32'h1001_1800);
    wr(10'h000, 32'h1000_1800); idle(1);
    chk("R9 irq after clear", 32'(irq), 0);
    rd(10'h000, d); chk("R5 cleared stays clear", d, 32'h0001_1800);
    pin_in[0] = 1'b0; idle(6);
    rd(10'h000, d); chk("R5 fall ignored in rise mode", d, 32'h0000_1800);

    // R5: falling on pin 6
    wr(10'h018, 32'h0000_1A00);
    pin_in[6] = 1'b1; idle(6);
    rd(10'h018, d); chk("R5 rise ignored in fall mode", d, 32'h0001_1A00);
    pin_in[6] = 1'b0; idle(6);
    rd(10'h018, d); chk("R5 fall status", d, 32'h1000_1A00);
    rd(10'h2F8, d); chk("R8 summary group1", d, 2);
    wr(10'h018, 32'h1000_1A00);

    // R5: both edges on pin 9
    wr(10'h024, 32'h0000_1C00);
    pin_in[9] = 1'b1; idle(6);
    rd(10'h024, d); chk("R5 both rise", d, 32'h1001_1C00);
    wr(10'h024, 32'h1000_1C00);
    pin_in[9] = 1'b0; idle(6);
    rd(10'h024, d); chk("R5 both fall", d, 32'h1000_1C00);
    wr(10'h024, 32'h1000_1C00);

    // R6: level high on pin 12
    wr(10'h030, 32'h0000_1900);
    pin_in[12] = 1'b1; idle(6);
    wr(10'h030, 32'h1000_1900);
    rd(10'h030, d); chk("R6 clear while active", d, 32'h1001_1900);
    pin_in[12] = 1'b0; idle(6);
    rd(10'h030, d); chk("R6 latched after inactive", d, 32'h1000_1900);
    wr(10'h030, 32'h1000_1900);
    rd(10'h030, d); chk("R6 clear when inactive", d, 32'h0000_1900);

    // R6: level low on pin 13
    wr(10'h034, 32'h0000_1B00); idle(3);
    rd(10'h034, d); chk("R6 low level status", d, 32'h1000_1B00);
    pin_in[13] = 1'b1; idle(6);
    wr(10'h034, 32'h1000_1B00);
    rd(10'h034, d); chk("R6 low level cleared", d, 32'h0001_1B00);
    wr(10'h034, 32'h0); pin_in[13] = 1'b0;

    // R7: detection off on pin 20
    wr(10'h050, 32'h0000_1000);
    pin_in[20] = 1'b1; idle(6); pin_in[20] = 1'b0; idle(6);
    rd(10'h050, d); chk("R7 no status when disabled", d, 32'h0000_1000);
    chk("R7 irq quiet", 32'(irq), 0);

    // R8: delivery masked on pin 21
    wr(10'h054, 32'h0000_0800);
    pin_in[21] = 1'b1; idle(6);
    rd(10'h054, d); chk("R8 masked status visible", d, 32'h1001_0800);
    rd(10'h2F8, d); chk("R8 masked not summarized", d, 0);
    chk("R9 masked no irq", 32'(irq), 0);
    rd(10'h2FC, d); chk("R8 high summary empty", d, 0);
    wr(10'h054, 32'h1000_0000);

    // R10: end-of-interrupt with status still pending
    wr(10'h000, 32'h0000_1800);
    pin_in[0] = 1'b1; idle(6);
    chk("R9 irq before eoi", 32'(irq), 1);
    wr(10'h0FC, 32'h2000_0000);
    chk("R10 low after eoi", 32'(irq), 0);
    idle(1);
    chk("R10 reasserted after eoi", 32'(irq), 1);
    rd(10'h0FC, d); chk("R10 eoi self-clears", d, 0);
    wr(10'h000, 32'h1000_1800);

    // random phase compared against the model every cycle
    for (int i = 0; i < 800; i++) begin
      int op = $urandom % 6;
      if ($urandom % 4 == 0) pin_in = $urandom;
      reg_wr = 1'b0; reg_rd = 1'b0;
      case (op)
        0, 1: begin reg_wr = 1'b1; reg_addr = 10'(($urandom % 34) * 4); reg_wdata = $urandom; end
        2, 3: begin
          reg_rd = 1'b1;
          case ($urandom % 4)
            0: reg_addr = 10'h2F8;
            1: reg_addr = 10'h2FC;
            2: reg_addr = 10'h0FC;
            default: reg_addr = 10'(($urandom % 34) * 4);
          endcase
        end
        4: begin reg_wr = 1'b1; reg_addr = 10'h0FC; reg_wdata = 32'h2000_0000; end
        default: ;
      endcase
      @(negedge clk);
    end
    reg_wr = 1'b0; reg_rd = 1'b0;
    idle(2);
    finish_run();
  end
endmodule